// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of ownership tokens that two independent agents, a left port and a right port, use to coordinate access to shared resources. Each token has at most one owner. While a port owns a token, the resource tied to that token is treated as in use. A port reaches the bank through a dedicated semaphore select. The select stands in for the memory chip enable, so the same address, data, write-enable and output-enable wires can drive either the memory or the tokens.

A write with the select asserted picks a token from the low address bits and uses data bit 0 as the command: 0 asks for the token and 1 gives it back. A request for a free token is granted at once. A request for a token the other port holds is remembered and is granted automatically when the owner lets go. When both ports ask for the same free token in one cycle, the left port wins. A read needs the select and the output enable together. It reports one cycle later whether the reading port owns the addressed token.

Top module: `token_sem_bank`

## Requirements
- R1: The bank holds eight tokens. The token index is taken from address bits [2:0], and all higher address bits are ignored. When the semaphore select of a port is low, that port has no effect on any token.
- R2: No token is ever owned by both ports at the same time.
- R3: A write (select=1, write enable=1) with data bit 0 equal to 0 requests the addressed token. If the token is free, the requesting port owns it from the next cycle on.
- R4: A request for a token held by the other port is kept pending. When the owner releases that token, the pending port becomes the owner on the same clock edge.
- R5: A write with data bit 0 equal to 1 releases the token only if the writing port owns it, and the token becomes free unless the other port is waiting for it. If the writing port does not own the token, ownership does not change and the port's own pending request for that token is withdrawn.
- R6: If both ports request the same free token in one cycle, the left port becomes the owner and the right port's request becomes pending.
- R7: A read (select=1, output enable=1, write enable=0) drives the port's read data one cycle later. Every bit is 0 if the reading port owned the addressed token at the read edge, and 1 otherwise. When the port is not reading, its read data is all ones.
- R8: After synchronous active-low reset, every token is free, no request is pending, and both read data buses are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sem_sel | input | 1 | Left semaphore select (in place of chip enable) |
| l_wr_en | input | 1 | Left write enable |
| l_out_en | input | 1 | Left output enable |
| l_addr | input | ADDR_W (16) | Left address; bits [2:0] pick the token |
| l_wdata | input | DATA_W (16) | Left write data; bit 0 is request(0)/release(1) |
| l_rdata | output | DATA_W (16) | Left read data, registered |
| r_sem_sel | input | 1 | Right semaphore select |
| r_wr_en | input | 1 | Right write enable |
| r_out_en | input | 1 | Right output enable |
| r_addr | input | ADDR_W (16) | Right address; bits [2:0] pick the token |
| r_wdata | input | DATA_W (16) | Right write data; bit 0 is request(0)/release(1) |
| r_rdata | output | DATA_W (16) | Right read data, registered |

## Verification
Several properties are checked on every cycle. No token is ever held twice. A deselected pair of ports leaves ownership unchanged. A request for a free token is granted, with the left port taking a simultaneous tie. A release while the other port waits hands the token over. A stray release changes nothing, and read data follows the ownership at the read edge. A request that waits for many cycles before its grant, and a pending request withdrawn by a stray release, appear only in the bench's sequences. The bench checks these against its own model of ownership and pending state.

// File: rtl/tsb_pkg.sv
// Shared types for the two-port token bank.
// Assumes: two ports only; a token is free or held by exactly one side.
package tsb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/tsb_port_decode.sv
// Decodes one port's controls into per-token request/release strobes
// and a read strobe with its token index.
// Assumes: NUM_TOK is a power of two; data bit 0 carries the command.
module tsb_port_decode #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_TOK = 8,
    localparam int IDX_W  = $clog2(NUM_TOK)
) (
    input  logic              sem_sel,
    input  logic              wr_en,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_TOK-1:0] req_vec,
    output logic [NUM_TOK-1:0] rel_vec,
    output logic              rd_stb,
    output logic [IDX_W-1:0]  rd_idx
);
    logic             wr_op;
    logic [IDX_W-1:0] idx;

    // Qualify write and read with the semaphore select.
    always_comb begin
        idx    = addr[IDX_W-1:0];
        wr_op  = sem_sel && wr_en;
        rd_stb = sem_sel && out_en && !wr_en;
        rd_idx = idx;
    end

    // One strobe pair per token.
    for (genvar k = 0; k < NUM_TOK; k++) begin : g_tok
        always_comb begin
            req_vec[k] = wr_op && !wdata[0] && (idx == IDX_W'(k));
            rel_vec[k] = wr_op &&  wdata[0] && (idx == IDX_W'(k));
        end
    end
endmodule

// File: rtl/tsb_token_cell.sv
// One token: owner state plus one pending-request flag per side.
// Left wins a same-cycle tie on a free token; a release by the owner
// hands the token to a waiting peer on the same edge.
// Assumes: a port issues at most one of request/release per cycle.
module tsb_token_cell
    import tsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);
    owner_e owner_q, owner_d;
    logic   pl_q, pl_d, pr_q, pr_d;

    // Next owner and pending flags from this cycle's strobes.
    always_comb begin
        owner_d = owner_q;
        pl_d    = pl_q;
        pr_d    = pr_q;
        if (l_rel) pl_d = 1'b0;
        if (r_rel) pr_d = 1'b0;
        unique case (owner_q)
            OWN_NONE: begin
                if (l_req) begin
                    owner_d = OWN_LEFT;
                    if (r_req) pr_d = 1'b1;
                end else if (r_req) begin
                    owner_d = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                if (r_req) pr_d = 1'b1;
                if (l_rel) begin
                    if (pr_d) begin
                        owner_d = OWN_RIGHT;
                        pr_d    = 1'b0;
                    end else begin
                        owner_d = OWN_NONE;
                    end
                end
            end
            OWN_RIGHT: begin
                if (l_req) pl_d = 1'b1;
                if (r_rel) begin
                    if (pl_d) begin
                        owner_d = OWN_LEFT;
                        pl_d    = 1'b0;
                    end else begin
                        owner_d = OWN_NONE;
                    end
                end
            end
            default: owner_d = OWN_NONE;
        endcase
    end

    // State register with synchronous reset to free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
            pl_q    <= 1'b0;
            pr_q    <= 1'b0;
        end else begin
            owner_q <= owner_d;
            pl_q    <= pl_d;
            pr_q    <= pr_d;
        end
    end

    // Flatten state for the bank.
    always_comb begin
        own_l  = (owner_q == OWN_LEFT);
        own_r  = (owner_q == OWN_RIGHT);
        pend_l = pl_q;
        pend_r = pr_q;
    end
endmodule

// File: rtl/tsb_read_port.sv
// Registered read path for one port: 0s if the port owns the addressed
// token at the read edge, 1s otherwise; all ones when not reading.
// Assumes: own_vec reflects state before the current edge's update.
module tsb_read_port #(
    parameter int DATA_W  = 16,
    parameter int NUM_TOK = 8,
    localparam int IDX_W  = $clog2(NUM_TOK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [NUM_TOK-1:0] own_vec,
    output logic [DATA_W-1:0]  rdata
);
    // Capture ownership status of the selected token.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '1;
        else if (rd_stb) rdata <= {DATA_W{~own_vec[rd_idx]}};
        else             rdata <= '1;
    end
endmodule

// File: rtl/token_sem_bank.sv
// Two-port bank of single-owner tokens reached through a semaphore
// select. Decodes each port, updates one cell per token, and returns
// registered ownership status on reads.
// Assumes: both ports share one clock; synchronous active-low reset.
module token_sem_bank #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_TOK = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_sel,
    input  logic              l_wr_en,
    input  logic              l_out_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_sel,
    input  logic              r_wr_en,
    input  logic              r_out_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NUM_TOK);

    logic [NUM_TOK-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_TOK-1:0] own_l, own_r, pend_l, pend_r;
    logic               l_rd_stb, r_rd_stb;
    logic [IDX_W-1:0]   l_rd_idx, r_rd_idx;

    tsb_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TOK(NUM_TOK)) u_dec_l (
        .sem_sel(l_sem_sel), .wr_en(l_wr_en), .out_en(l_out_en),
        .addr(l_addr), .wdata(l_wdata),
        .req_vec(l_req), .rel_vec(l_rel), .rd_stb(l_rd_stb), .rd_idx(l_rd_idx)
    );

    tsb_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TOK(NUM_TOK)) u_dec_r (
        .sem_sel(r_sem_sel), .wr_en(r_wr_en), .out_en(r_out_en),
        .addr(r_addr), .wdata(r_wdata),
        .req_vec(r_req), .rel_vec(r_rel), .rd_stb(r_rd_stb), .rd_idx(r_rd_idx)
    );

    for (genvar k = 0; k < NUM_TOK; k++) begin : g_cell
        tsb_token_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[k]), .l_rel(l_rel[k]),
            .r_req(r_req[k]), .r_rel(r_rel[k]),
            .own_l(own_l[k]), .own_r(own_r[k]),
            .pend_l(pend_l[k]), .pend_r(pend_r[k])
        );
    end

    tsb_read_port #(.DATA_W(DATA_W), .NUM_TOK(NUM_TOK)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_stb(l_rd_stb), .rd_idx(l_rd_idx),
        .own_vec(own_l), .rdata(l_rdata)
    );

    tsb_read_port #(.DATA_W(DATA_W), .NUM_TOK(NUM_TOK)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_stb(r_rd_stb), .rd_idx(r_rd_idx),
        .own_vec(own_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/token_sem_bank_chk.sv
// Checker for token_sem_bank, attached by bind. Watches ports plus the
// ownership and pending vectors that the token cells drive.
module token_sem_bank_chk #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_TOK = 8,
    localparam int IDX_W  = $clog2(NUM_TOK)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sem_sel,
    input logic               l_wr_en,
    input logic               l_out_en,
    input logic [ADDR_W-1:0]  l_addr,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sem_sel,
    input logic               r_wr_en,
    input logic [ADDR_W-1:0]  r_addr,
    input logic [DATA_W-1:0]  r_wdata,
    input logic [NUM_TOK-1:0] own_l,
    input logic [NUM_TOK-1:0] own_r,
    input logic [NUM_TOK-1:0] pend_l,
    input logic [NUM_TOK-1:0] pend_r
);
    logic [IDX_W-1:0] li, ri;
    logic l_rq, l_rl, r_rq, r_rl, l_rd, l_own_sel;

    always_comb begin
        li        = l_addr[IDX_W-1:0];
        ri        = r_addr[IDX_W-1:0];
        l_rq      = l_sem_sel && l_wr_en && !l_wdata[0];
        l_rl      = l_sem_sel && l_wr_en &&  l_wdata[0];
        r_rq      = r_sem_sel && r_wr_en && !r_wdata[0];
        r_rl      = r_sem_sel && r_wr_en &&  r_wdata[0];
        l_rd      = l_sem_sel && l_out_en && !l_wr_en;
        l_own_sel = own_l[li];
    end

    a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sem_sel && !r_sem_sel) |=> ($stable(own_l) && $stable(own_r)));

    a_r3_free_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rq && !own_l[li] && !own_r[li]) |=> own_l[$past(li)]);

    a_r4_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rl && own_l[li] && pend_r[li] && !r_rl) |=> own_r[$past(li)]);

    a_r5_stray_release: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rl && !own_l[li] && !(r_sem_sel && r_wr_en))
        |=> (own_l == $past(own_l) && own_r == $past(own_r)));

    a_r6_left_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rq && r_rq && li == ri && !own_l[li] && !own_r[li])
        |=> (own_l[$past(li)] && pend_r[$past(li)]));

    a_r7_read_status: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd |=> (l_rdata == {DATA_W{!$past(l_own_sel)}}));

    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (own_l == '0 && own_r == '0 && pend_l == '0 && pend_r == '0));
endmodule

bind token_sem_bank token_sem_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TOK(NUM_TOK)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_wr_en(l_wr_en), .l_out_en(l_out_en),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_wr_en(r_wr_en),
    .r_addr(r_addr), .r_wdata(r_wdata),
    .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/token_sem_bank_test.sv
module token_sem_bank_test;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sem_sel = 1'b0, l_wr_en = 1'b0, l_out_en = 1'b0;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic          r_sem_sel = 1'b0, r_wr_en = 1'b0, r_out_en = 1'b0;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] r_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model: 0 free, 1 left, 2 right; pending per side.
    int m_own [8];
    bit m_pl  [8];
    bit m_pr  [8];

    always #10 clk = ~clk;  // 50 MHz

    token_sem_bank uut (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_wr_en(l_wr_en), .l_out_en(l_out_en),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_sel(r_sem_sel), .r_wr_en(r_wr_en), .r_out_en(r_out_en),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] read_exp(bit rd, int own, int side);
        if (rd && own == side) return '0;
        return '1;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_own[k] = 0; m_pl[k] = 0; m_pr[k] = 0;
        end
    endtask

    // Apply the requirement rules to the model for one edge.
    task automatic model_step(bit lq, bit lf, int li, bit rq, bit rf, int ri);
        for (int k = 0; k < 8; k++) begin
            bit a_q = lq && li == k, a_f = lf && li == k;
            bit b_q = rq && ri == k, b_f = rf && ri == k;
            if (a_f && m_own[k] != 1) m_pl[k] = 0;
            if (b_f && m_own[k] != 2) m_pr[k] = 0;
            if (m_own[k] == 0) begin
                if (a_q) begin m_own[k] = 1; if (b_q) m_pr[k] = 1; end
                else if (b_q) m_own[k] = 2;
            end else if (m_own[k] == 1) begin
                if (b_q) m_pr[k] = 1;
                if (a_f) begin
                    if (m_pr[k]) begin m_own[k] = 2; m_pr[k] = 0; end
                    else m_own[k] = 0;
                end
            end else begin
                if (a_q) m_pl[k] = 1;
                if (b_f) begin
                    if (m_pl[k]) begin m_own[k] = 1; m_pl[k] = 0; end
                    else m_own[k] = 0;
                end
            end
        end
    endtask

    // One cycle: drive at negedge, edge, compare at next negedge.
    task automatic cyc(string tag,
                       bit ls, bit lw, bit lo, logic [AW-1:0] la, bit lb,
                       bit rs, bit rw, bit ro, logic [AW-1:0] ra, bit rb);
        logic [DW-1:0] el, er;
        int li = int'(la[2:0]);
        int ri = int'(ra[2:0]);
        l_sem_sel = ls; l_wr_en = lw; l_out_en = lo; l_addr = la;
        l_wdata = {$urandom} ; l_wdata[0] = lb;
        r_sem_sel = rs; r_wr_en = rw; r_out_en = ro; r_addr = ra;
        r_wdata = {$urandom} ; r_wdata[0] = rb;
        el = read_exp(ls && lo && !lw, m_own[li], 1);
        er = read_exp(rs && ro && !rw, m_own[ri], 2);
        model_step(ls && lw && !lb, ls && lw && lb, li,
                   rs && rw && !rb, rs && rw && rb, ri);
        @(posedge clk);
        @(negedge clk);
        check({tag, " left"}, l_rdata, el);
        check({tag, " right"}, r_rdata, er);
    endtask

    task automatic idle();
        cyc("R7 idle", 0,0,0,16'h0,0, 0,0,0,16'h0,0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(negedge clk);
        check("R8 reset left", l_rdata, '1);
        check("R8 reset right", r_rdata, '1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++)
            cyc("R8 all free", 1,0,1,16'(k),0, 1,0,1,16'(k),0);
        // R3/R1: left takes token 3 via address with high bits set.
        cyc("R3 request", 1,1,0,16'hABC3,0, 0,0,0,16'h0,0);
        cyc("R1 R3 read", 1,0,1,16'h0003,0, 1,0,1,16'h7F03,0);
        // R4: right waits, then is granted on release.
        cyc("R4 pend", 0,0,0,16'h0,0, 1,1,0,16'h0003,0);
        cyc("R4 still held", 1,0,1,16'h0003,0, 1,0,1,16'h0003,0);
        cyc("R4 release", 1,1,0,16'h0003,1, 0,0,0,16'h0,0);
        cyc("R4 handed over", 1,0,1,16'h0003,0, 1,0,1,16'h0003,0);
        // R5: stray release from the left.
        cyc("R5 stray", 1,1,0,16'h0003,1, 0,0,0,16'h0,0);
        cyc("R5 unchanged", 1,0,1,16'h0003,0, 1,0,1,16'h0003,0);
        // R5: left pends, withdraws via stray release, right releases.
        cyc("R5 pend", 1,1,0,16'h0003,0, 0,0,0,16'h0,0);
        cyc("R5 withdraw", 1,1,0,16'h0003,1, 0,0,0,16'h0,0);
        cyc("R5 owner rel", 0,0,0,16'h0,0, 1,1,0,16'h0003,1);
        cyc("R5 freed", 1,0,1,16'h0003,0, 1,0,1,16'h0003,0);
        // R6: tie on token 5.
        cyc("R6 tie", 1,1,0,16'h0005,0, 1,1,0,16'h1235,0);
        cyc("R6 left wins", 1,0,1,16'h0005,0, 1,0,1,16'h0005,0);
        cyc("R6 R4 rel", 1,1,0,16'h0005,1, 0,0,0,16'h0,0);
        cyc("R6 R4 right got", 1,0,1,16'h0005,0, 1,0,1,16'h0005,0);
        // R1: deselected write has no effect.
        cyc("R1 no sel", 0,1,0,16'h0001,0, 0,1,0,16'h0001,0);
        cyc("R1 still free", 1,0,1,16'h0001,0, 1,0,1,16'h0001,0);
        // R7: write with output enable does not read.
        cyc("R7 wr no read", 1,1,1,16'h0002,0, 0,0,0,16'h0,0);
        cyc("R7 owner read", 1,0,1,16'h0002,0, 0,0,0,16'h0,0);
        idle();
        // Random mix, R2 R3 R4 R5 R6 R7 against the model.
        for (int i = 0; i < 3000; i++) begin
            cyc("R2 random",
                ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
                16'($urandom), $urandom % 2,
                ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
                16'($urandom), $urandom % 2);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule